// File: doc/BRIEF.md
# UART Register and Interrupt Front-End

This block sits between a simple memory-mapped bus and a byte-oriented serial core. It has no FIFOs. It decodes 1-, 2- and 4-byte accesses at word-aligned offsets. A write to the data register passes a byte to the transmit stream. A read of the data register pulls one byte from a single receive-holding slot that the serial side keeps presented, with a valid level.

The block holds the baud divisor, line-format, control and level-select words so that software can read them back. It keeps an 11-bit raw interrupt register and a mask register, and it drives one interrupt line. That line rises a programmable number of cycles after the masked status becomes nonzero, and it falls in the same cycle that the masked status returns to zero.

Requests complete in one cycle. Read data and the error response are combinational on the request. Register side effects take place at the clock edge that ends the request.

Top module: `uart_regfront`

Register offsets (byte address): 0x00 data, 0x04 receive error/status, 0x08 flags, 0x0C integer divisor, 0x10 fractional divisor, 0x14 line format, 0x18 control, 0x1C level select, 0x20 interrupt mask, 0x24 raw status, 0x28 masked status, 0x2C interrupt clear, 0x30 DMA control. Interrupt bits: receive = bit 4, transmit = bit 5, receive timeout = bit 6.

## Requirements
- R1: After reset, control reads 0x300 and level select reads 0x12. The two divisor words, the line format, the mask and the raw status all read 0.
- R2: A read of offset 0x00 while `rx_valid` is high returns `rx_byte` in bits 7:0, pulses `rx_take` in the same cycle, and clears raw bits 4 and 6. If `rx_valid` is high again in the following cycle, bits 4 and 6 are set again.
- R3: Offset 0x04 always reads 0, and writes to it change no state.
- R4: The flags word is bit 0 = 1 (clear to send), bit 4 = receive empty (`!rx_valid`), bit 5 = 0 (transmit full), bit 6 = receive full (`rx_valid`), bit 7 = 1 (transmit empty). All other bits are 0.
- R5: An accepted write of offset 0x00 gives `tx_valid` high for one cycle on the next cycle, with `tx_byte` equal to the low 8 bits written. Raw bit 5 is set from that cycle on.
- R6: The mask register keeps only bits 10:0 of a write. Offset 0x28 reads raw status AND mask.
- R7: A write to offset 0x2C clears every raw bit that is set in the written value. If `rx_valid` is high during that write, raw bits 4 and 6 are set again.
- R8: Let the first cycle in which raw AND mask is nonzero be cycle N. Then `irq` is high from cycle N+IRQ_DELAY onward, and it is low in every cycle in which raw AND mask is zero. A delay that is already running is not restarted by further interrupt sources.
- R9: If the masked status returns to zero before the delay expires, the pending assertion is dropped, and a later onset starts a full new delay.
- R10: Writing DMA control with any of bits 2:0 set raises `dma_fault`, which stays high until reset. Writes with only other bits set do not raise it. DMA control always reads 0.
- R11: With END_ON_EOT set, transmitting byte 0x04 raises `eot_stop`, which stays high until reset.
- R12: A request with a size other than 1, 2 or 4, a nonzero address bits 1:0, or an offset above 0x30 raises `bus_err` in that cycle. Such a request has no effect and returns 0.
- R13: Access size selects the low 1, 2 or 4 bytes: write data above the size is discarded, and read data above the size returns 0.
- R14: When `rx_valid` rises, raw bits 4 and 6 are set in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data, little-endian lanes |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | Error response, combinational |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive slot holds a byte |
| rx_byte | input | 8 | Held receive byte |
| rx_take | output | 1 | Held byte consumed this cycle |
| irq | output | 1 | Interrupt line |
| eot_stop | output | 1 | End-of-transmission seen (sticky) |
| dma_fault | output | 1 | DMA enable attempted (sticky) |

## Verification
The bench builds the block with IRQ_DELAY = 3 and END_ON_EOT = 1. A delay of three cycles leaves room to clear the masked status one cycle into a pending delay, and to add a second interrupt source while the count is still running. These two cases show cancellation and the rule that a running delay is not restarted. With end-of-transmission detection enabled, the byte 0x04 is checked against ordinary bytes.

// File: rtl/uart_regfront.sv
module uart_regfront #(
  parameter int IRQ_DELAY  = 3,
  parameter bit END_ON_EOT = 1,
  parameter int INT_W      = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [5:0]  bus_addr,
  input  logic [2:0]  bus_size,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_err,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic        rx_take,
  output logic        irq,
  output logic        eot_stop,
  output logic        dma_fault
);
  localparam int CW = $clog2(IRQ_DELAY + 1) + 1;
  localparam logic [INT_W-1:0] RXB = INT_W'(7'h50);
  localparam logic [INT_W-1:0] TXB = INT_W'(7'h20);

  logic [15:0] ctrl_q, divi_q;
  logic [5:0]  divf_q, lvl_q;
  logic [7:0]  line_q;
  logic [INT_W-1:0] mask_q, raw_q, raw_d;
  logic rxv_q, take_q, irq_q, pend_q;
  logic [CW-1:0] cnt_q;

  logic [3:0]  sel;
  logic        size_ok, mapped, acc, wr, rd, refill, masked_any;
  logic [31:0] lane, wd, word;

  assign sel     = bus_addr[5:2];
  assign size_ok = (bus_size == 3'd1) || (bus_size == 3'd2) || (bus_size == 3'd4);
  assign mapped  = (bus_addr[1:0] == 2'b00) && (sel <= 4'd12);
  assign acc     = bus_valid && size_ok && mapped;
  assign bus_err = bus_valid && !acc;
  assign wr      = acc && bus_write;
  assign rd      = acc && !bus_write;
  assign lane    = (bus_size == 3'd1) ? 32'hFF : (bus_size == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
  assign wd      = bus_wdata & lane;
  assign rx_take = rd && (sel == 4'd0) && rx_valid;
  assign masked_any = |(raw_q & mask_q);
  assign irq     = irq_q && masked_any;

  always_comb begin
    case (sel)
      4'd0:    word = rx_valid ? 32'(rx_byte) : 32'h0;
      4'd2:    word = {24'h0, 1'b1, rx_valid, 1'b0, !rx_valid, 3'b000, 1'b1};
      4'd3:    word = 32'(divi_q);
      4'd4:    word = 32'(divf_q);
      4'd5:    word = 32'(line_q);
      4'd6:    word = 32'(ctrl_q);
      4'd7:    word = 32'(lvl_q);
      4'd8:    word = 32'(mask_q);
      4'd9:    word = 32'(raw_q);
      4'd10:   word = 32'(raw_q & mask_q);
      default: word = 32'h0;
    endcase
  end
  assign bus_rdata = rd ? (word & lane) : 32'h0;

  assign refill = rx_valid && (!rxv_q || take_q || (wr && sel == 4'd11));

  always_comb begin
    raw_d = raw_q;
    if (wr && sel == 4'd11) raw_d = raw_d & ~wd[INT_W-1:0];
    if (rx_take)            raw_d = raw_d & ~RXB;
    if (wr && sel == 4'd0)  raw_d = raw_d | TXB;
    if (refill)             raw_d = raw_d | RXB;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= 16'h0300; lvl_q <= 6'h12; divi_q <= '0; divf_q <= '0; line_q <= '0;
      mask_q <= '0; raw_q <= '0; rxv_q <= 1'b0; take_q <= 1'b0;
      tx_valid <= 1'b0; tx_byte <= '0; eot_stop <= 1'b0; dma_fault <= 1'b0;
    end else begin
      raw_q    <= raw_d;
      rxv_q    <= rx_valid;
      take_q   <= rx_take;
      tx_valid <= wr && sel == 4'd0;
      if (wr) begin
        case (sel)
          4'd0: begin
            tx_byte <= wd[7:0];
            if (END_ON_EOT && wd[7:0] == 8'h04) eot_stop <= 1'b1;
          end
          4'd3:  divi_q <= wd[15:0];
          4'd4:  divf_q <= wd[5:0];
          4'd5:  line_q <= wd[7:0];
          4'd6:  ctrl_q <= wd[15:0];
          4'd7:  lvl_q  <= wd[5:0];
          4'd8:  mask_q <= wd[INT_W-1:0];
          4'd12: if (|wd[2:0]) dma_fault <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0; pend_q <= 1'b0; cnt_q <= '0;
    end else if (!masked_any) begin
      irq_q <= 1'b0; pend_q <= 1'b0;
    end else if (pend_q) begin
      if (cnt_q <= CW'(1)) begin
        irq_q <= 1'b1; pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end else if (!irq_q) begin
      if (IRQ_DELAY <= 1) irq_q <= 1'b1;
      else begin
        pend_q <= 1'b1;
        cnt_q  <= CW'(IRQ_DELAY - 1);
      end
    end
  end
endmodule

module uart_regfront_chk #(parameter int INT_W = 11) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [5:0]       bus_addr,
  input logic             bus_err,
  input logic             tx_valid,
  input logic             rx_take,
  input logic             irq,
  input logic             eot_stop,
  input logic             dma_fault,
  input logic [INT_W-1:0] raw_q,
  input logic [INT_W-1:0] mask_q
);
  AST_TX_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_valid && bus_write && !bus_err && bus_addr == 6'h00)); // R5
  AST_TX_RAISES_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !bus_err && bus_addr == 6'h00) |=> raw_q[5]); // R5
  AST_IRQ_NEEDS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(raw_q & mask_q))); // R8
  AST_IRQ_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(raw_q & mask_q))); // R8
  AST_DMA_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    dma_fault |=> dma_fault); // R10
  AST_EOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    eot_stop |=> eot_stop); // R11
  AST_ERR_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !rx_take); // R12
endmodule

bind uart_regfront uart_regfront_chk #(.INT_W(INT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_err(bus_err), .tx_valid(tx_valid), .rx_take(rx_take),
  .irq(irq), .eot_stop(eot_stop), .dma_fault(dma_fault), .raw_q(raw_q), .mask_q(mask_q)
);

// File: tb/sim_uart_regfront.sv
module sim_uart_regfront;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 3;

  logic clk = 0, rst_n = 0;
  logic bv = 0, bw = 0;
  logic [5:0] ba = 0;
  logic [2:0] bs = 4;
  logic [31:0] bwd = 0;
  logic rxv = 0;
  logic [7:0] rxb = 0;
  logic [31:0] rdata;
  logic err, txv, take, irq, eot, dmaf;
  logic [7:0] txb;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regfront #(.IRQ_DELAY(DLY), .END_ON_EOT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bv), .bus_write(bw), .bus_addr(ba),
    .bus_size(bs), .bus_wdata(bwd), .bus_rdata(rdata), .bus_err(err),
    .tx_valid(txv), .tx_byte(txb), .rx_valid(rxv), .rx_byte(rxb), .rx_take(take),
    .irq(irq), .eot_stop(eot), .dma_fault(dmaf));

  int checks = 0, fails = 0, n = 0, onset = -1;
  string tag = "R1";

  int m_raw, m_mask, m_ctrl, m_lvl, m_divi, m_divf, m_line;
  bit m_txv, m_eot, m_dma, m_prv, m_ptake;
  int m_txb;

  function automatic int lanes(int s);
    return (s == 1) ? 'hFF : (s == 2) ? 'hFFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic bit e_acc();
    return bv && (bs == 1 || bs == 2 || bs == 4) && ba[1:0] == 0 && ba <= 6'h30;
  endfunction
  function automatic int e_word();
    case (int'(ba))
      'h00: return rxv ? int'(rxb) : 0;
      'h08: return 'h81 | (rxv ? 'h40 : 'h10);
      'h0C: return m_divi;
      'h10: return m_divf;
      'h14: return m_line;
      'h18: return m_ctrl;
      'h1C: return m_lvl;
      'h20: return m_mask;
      'h24: return m_raw;
      'h28: return m_raw & m_mask;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, n, act, exp);
    end
  endtask

  task automatic compare();
    bit acc = e_acc();
    bit rd  = acc && !bw;
    bit nz  = (m_raw & m_mask) != 0;
    chk("rdata", rdata, rd ? (e_word() & lanes(bs)) : 0);
    chk("err", err, bv && !acc);
    chk("take", take, rd && ba == 0 && rxv);
    chk("irq", irq, nz && onset >= 0 && (n - onset) >= DLY);
    chk("tx_valid", txv, m_txv);
    if (m_txv) chk("tx_byte", txb, m_txb);
    chk("eot", eot, m_eot);
    chk("dma_fault", dmaf, m_dma);
  endtask

  task automatic model_edge();
    bit acc = e_acc();
    bit wr = acc && bw;
    bit tk = acc && !bw && ba == 0 && rxv;
    int w = bwd & lanes(bs);
    int nr = m_raw;
    if (wr && ba == 'h2C) nr &= ~(w & 'h7FF);
    if (tk) nr &= ~'h50;
    if (wr && ba == 'h00) nr |= 'h20;
    if (rxv && (!m_prv || m_ptake || (wr && ba == 'h2C))) nr |= 'h50;
    m_txv = wr && ba == 'h00;
    if (m_txv) begin
      m_txb = w & 'hFF;
      if (m_txb == 4) m_eot = 1;
    end
    if (wr) begin
      case (int'(ba))
        'h0C: m_divi = w & 'hFFFF;
        'h10: m_divf = w & 'h3F;
        'h14: m_line = w & 'hFF;
        'h18: m_ctrl = w & 'hFFFF;
        'h1C: m_lvl  = w & 'h3F;
        'h20: m_mask = w & 'h7FF;
        'h30: if ((w & 7) != 0) m_dma = 1;
        default: ;
      endcase
    end
    m_prv = rxv; m_ptake = tk; m_raw = nr;
    n++;
    if ((m_raw & m_mask) == 0) onset = -1;
    else if (onset < 0) onset = n;
  endtask

  task automatic cyc();
    #1 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic access(bit w, int a, int s, int d);
    bv = 1; bw = w; ba = 6'(a); bs = 3'(s); bwd = d;
    cyc();
    bv = 0; bw = 0;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cyc();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    m_raw = 0; m_mask = 0; m_ctrl = 'h300; m_lvl = 'h12; m_divi = 0; m_divf = 0; m_line = 0;
    m_txv = 0; m_txb = 0; m_eot = 0; m_dma = 0; m_prv = 0; m_ptake = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    tag = "R1";
    access(0, 'h18, 4, 0); access(0, 'h1C, 4, 0); access(0, 'h0C, 4, 0);
    access(0, 'h10, 4, 0); access(0, 'h14, 4, 0); access(0, 'h20, 4, 0); access(0, 'h24, 4, 0);

    tag = "R4"; access(0, 'h08, 4, 0);
    tag = "R3"; access(1, 'h04, 4, 'hFF); access(0, 'h04, 4, 0); access(0, 'h24, 4, 0);

    tag = "R13";
    access(1, 'h0C, 1, 'h1234); access(0, 'h0C, 4, 0);
    access(1, 'h0C, 2, 'hABCD_5678); access(0, 'h0C, 1, 0);
    access(0, 'h18, 1, 0); access(0, 'h18, 2, 0);
    access(1, 'h14, 4, 'h1A5); access(0, 'h14, 4, 0);

    tag = "R12";
    access(1, 'h18, 3, 'h55); access(0, 'h18, 4, 0);
    access(1, 'h1A, 2, 'h55); access(0, 'h34, 4, 0); access(1, 'h3C, 4, 'h1);
    access(0, 'h18, 0, 0); access(0, 'h18, 4, 0);

    tag = "R6";
    access(1, 'h20, 4, 'hFFFF); access(0, 'h20, 4, 0); access(1, 'h20, 4, 'h20);

    tag = "R14";
    rxv = 1; rxb = 8'h5A; cyc(); access(0, 'h24, 4, 0);
    tag = "R4"; access(0, 'h08, 4, 0);
    tag = "R2";
    access(0, 'h00, 4, 0); rxb = 8'hC3; access(0, 'h24, 4, 0);
    access(0, 'h00, 1, 0); rxv = 0; access(0, 'h24, 4, 0); access(0, 'h00, 4, 0);

    tag = "R5";
    access(1, 'h00, 4, 'h1241); idle(5);
    tag = "R6"; access(0, 'h28, 4, 0);
    tag = "R8"; access(1, 'h2C, 4, 'h20); idle(2);

    tag = "R9";
    access(1, 'h00, 1, 'h42); cyc(); access(1, 'h2C, 4, 'h7FF); idle(2);
    access(1, 'h00, 1, 'h43); idle(5);
    access(1, 'h2C, 4, 'h20);

    tag = "R8";
    access(1, 'h20, 4, 'h70);
    access(1, 'h00, 1, 'h44); rxv = 1; rxb = 8'h11; cyc(); idle(4);

    tag = "R7";
    access(1, 'h2C, 4, 'h7FF); access(0, 'h24, 4, 0); idle(4);
    rxv = 0; access(1, 'h2C, 4, 'h7FF); access(0, 'h24, 4, 0); idle(2);

    tag = "R10";
    access(1, 'h30, 4, 'h8); access(0, 'h30, 4, 0);
    access(1, 'h30, 4, 'h2); access(0, 'h30, 4, 0); idle(2);

    tag = "R11";
    access(1, 'h00, 4, 'h104); idle(2);
    access(1, 'h00, 4, 'h04); idle(3);

    summary();
  end
endmodule